// File: doc/BRIEF.md
# Device Test Result Classifier

This block turns the raw outcome of one thermal-delta device test into a single verdict. When the sequencer pulses `eval_req`, the block captures the pretest flags (contact failure, avalanche, oscillation), the two sampled device voltages in millivolts, and the programmed upper and lower delta limits. One clock later it presents a one-hot verdict together with a valid strobe.

The verdict comes from a fixed precedence chain. Contact failure wins over everything else. Next come the first-sample window checks, for a collapsed junction (short) or a missing one (open). After those come avalanche, then a sign error (the second sample above the first), then oscillation. Only when none of these apply is the delta (first sample minus second, saturated at 1999 mV) compared with the limits to give high, low or pass. The saturated delta is also reported with the strobe, so that it can be logged.

Top module: `verdict_sorter`

## Requirements
- R1: One clock after `eval_req` is sampled high, `verdict_vld` is high for exactly one clock and `verdict` has exactly one bit set. In every other cycle, including after reset, `verdict_vld` is low and `verdict` and `delta_mv` are zero. The verdict bit positions are: 0 pass, 1 low, 2 high, 3 oscillation, 4 sign error, 5 avalanche, 6 open, 7 short, 8 contact failure.
- R2: When `contact_fail` is high, the verdict is contact failure (bit 8), whatever the other inputs are.
- R3: Without a contact failure, a first sample below 200 mV gives short (bit 7) and a first sample above 3000 mV gives open (bit 6). The values 200 and 3000 themselves pass this check.
- R4: When the contact and window checks pass, a high `avalanche` gives the avalanche verdict (bit 5).
- R5: When none of the above applies and the first sample is below the second, the verdict is sign error (bit 4).
- R6: When none of the above applies and `oscillation` is high, the verdict is oscillation (bit 3), regardless of the limits.
- R7: `delta_mv` shown with the strobe equals first minus second, saturated to 1999. It is zero when the first sample is below the second.
- R8: Otherwise, a delta above the upper limit gives high (bit 2). If it is not high, a delta below the lower limit gives low (bit 1). Anything else gives pass (bit 0). A delta equal to a limit passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_req | input | 1 | Pulse: classify the inputs presented this cycle |
| contact_fail | input | 1 | Contact check failed |
| avalanche | input | 1 | Avalanche seen during forcing |
| oscillation | input | 1 | Oscillation seen during measurement |
| samp_first_mv | input | 12 | First (cold) sample, mV, 0..4095 |
| samp_second_mv | input | 12 | Second (heated) sample, mV |
| limit_hi_mv | input | 11 | Upper delta limit, mV, 0..1999 |
| limit_lo_mv | input | 11 | Lower delta limit, mV, 0..1999 |
| verdict | output | 9 | One-hot verdict, valid with the strobe |
| verdict_vld | output | 1 | One-clock result strobe |
| delta_mv | output | 11 | Saturated delta, valid with the strobe |

## Verification
The assertions check the strobe timing and the one-hot shape on every cycle. They also check that the delta never exceeds its ceiling, and that contact failure and a short first sample always win when they are present. The remaining precedence steps involve the order of several conditions at once: avalanche over sign error, oscillation over the limits, and the exact limit boundaries. These show up only in the bench scenarios, which compare each verdict with an independently computed expected value.

// File: rtl/vs_pkg.sv
package vs_pkg;
  localparam int NUM_V    = 9;
  localparam int V_PASS   = 0;
  localparam int V_LOW    = 1;
  localparam int V_HIGH   = 2;
  localparam int V_OSC    = 3;
  localparam int V_ERR    = 4;
  localparam int V_AVAL   = 5;
  localparam int V_OPEN   = 6;
  localparam int V_SHORT  = 7;
  localparam int V_CONTF  = 8;

  // a - b clamped to [0, cap]
  function automatic logic [15:0] sat_diff(input logic [15:0] a,
                                           input logic [15:0] b,
                                           input logic [15:0] cap);
    logic [15:0] d;
    if (a < b) return 16'd0;
    d = a - b;
    return (d > cap) ? cap : d;
  endfunction

  // highest set index of a condition vector, returned one-hot
  function automatic logic [NUM_V-1:0] top_pick(input logic [NUM_V-1:0] c);
    logic [NUM_V-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_V; i++)
      if (c[i]) r = NUM_V'(1) << i;
    return r;
  endfunction
endpackage

// File: rtl/vs_delta.sv
module vs_delta #(
  parameter int MV_W      = 12,
  parameter int D_W       = 11,
  parameter int DELTA_MAX = 1999
) (
  input  logic [MV_W-1:0] first_mv,
  input  logic [MV_W-1:0] second_mv,
  output logic [D_W-1:0]  delta_mv,
  output logic            sign_err
);
  import vs_pkg::*;
  logic [15:0] d16;
  assign sign_err = first_mv < second_mv;
  assign d16      = sat_diff(16'(first_mv), 16'(second_mv), 16'(DELTA_MAX));
  assign delta_mv = d16[D_W-1:0];
endmodule

// File: rtl/vs_window.sv
module vs_window #(
  parameter int MV_W     = 12,
  parameter int SHORT_MV = 200,
  parameter int OPEN_MV  = 3000
) (
  input  logic [MV_W-1:0] first_mv,
  output logic            short_hit,
  output logic            open_hit
);
  localparam logic [MV_W-1:0] SHORT_L = MV_W'(SHORT_MV);
  localparam logic [MV_W-1:0] OPEN_L  = MV_W'(OPEN_MV);
  assign short_hit = first_mv < SHORT_L;
  assign open_hit  = first_mv > OPEN_L;
endmodule

// File: rtl/vs_rank.sv
module vs_rank #(
  parameter int D_W = 11
) (
  input  logic                   contact_fail,
  input  logic                   short_hit,
  input  logic                   open_hit,
  input  logic                   avalanche,
  input  logic                   sign_err,
  input  logic                   oscillation,
  input  logic [D_W-1:0]         delta_mv,
  input  logic [D_W-1:0]         limit_hi_mv,
  input  logic [D_W-1:0]         limit_lo_mv,
  output logic [vs_pkg::NUM_V-1:0] pick
);
  import vs_pkg::*;
  logic [NUM_V-1:0] cond;
  always_comb begin
    cond          = '0;
    cond[V_PASS]  = 1'b1;
    cond[V_LOW]   = delta_mv < limit_lo_mv;
    cond[V_HIGH]  = delta_mv > limit_hi_mv;
    cond[V_OSC]   = oscillation;
    cond[V_ERR]   = sign_err;
    cond[V_AVAL]  = avalanche;
    cond[V_OPEN]  = open_hit;
    cond[V_SHORT] = short_hit;
    cond[V_CONTF] = contact_fail;
  end
  assign pick = top_pick(cond);
endmodule

// File: rtl/verdict_sorter.sv
module verdict_sorter #(
  parameter int MV_W      = 12,
  parameter int D_W       = 11,
  parameter int DELTA_MAX = 1999,
  parameter int SHORT_MV  = 200,
  parameter int OPEN_MV   = 3000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eval_req,
  input  logic                     contact_fail,
  input  logic                     avalanche,
  input  logic                     oscillation,
  input  logic [MV_W-1:0]          samp_first_mv,
  input  logic [MV_W-1:0]          samp_second_mv,
  input  logic [D_W-1:0]           limit_hi_mv,
  input  logic [D_W-1:0]           limit_lo_mv,
  output logic [vs_pkg::NUM_V-1:0] verdict,
  output logic                     verdict_vld,
  output logic [D_W-1:0]           delta_mv
);
  import vs_pkg::*;

  // named internal events
  logic [D_W-1:0]   delta_c;
  logic             sign_err;
  logic             short_hit;
  logic             open_hit;
  logic [NUM_V-1:0] pick;

  vs_delta #(.MV_W(MV_W), .D_W(D_W), .DELTA_MAX(DELTA_MAX)) u_delta (
    .first_mv (samp_first_mv),
    .second_mv(samp_second_mv),
    .delta_mv (delta_c),
    .sign_err (sign_err)
  );

  vs_window #(.MV_W(MV_W), .SHORT_MV(SHORT_MV), .OPEN_MV(OPEN_MV)) u_window (
    .first_mv (samp_first_mv),
    .short_hit(short_hit),
    .open_hit (open_hit)
  );

  vs_rank #(.D_W(D_W)) u_rank (
    .contact_fail(contact_fail),
    .short_hit   (short_hit),
    .open_hit    (open_hit),
    .avalanche   (avalanche),
    .sign_err    (sign_err),
    .oscillation (oscillation),
    .delta_mv    (delta_c),
    .limit_hi_mv (limit_hi_mv),
    .limit_lo_mv (limit_lo_mv),
    .pick        (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict     <= '0;
      verdict_vld <= 1'b0;
      delta_mv    <= '0;
    end else begin
      verdict_vld <= eval_req;
      verdict     <= eval_req ? pick    : '0;
      delta_mv    <= eval_req ? delta_c : '0;
    end
  end
endmodule

// File: rtl/vs_check.sv
module vs_check #(
  parameter int MV_W      = 12,
  parameter int D_W       = 11,
  parameter int DELTA_MAX = 1999,
  parameter int SHORT_MV  = 200
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     eval_req,
  input logic                     contact_fail,
  input logic [MV_W-1:0]          samp_first_mv,
  input logic [vs_pkg::NUM_V-1:0] verdict,
  input logic                     verdict_vld,
  input logic [D_W-1:0]           delta_mv
);
  import vs_pkg::*;

  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req |=> verdict_vld);
  assert_strobe_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> !verdict_vld);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $countones(verdict) == 1);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_vld |-> (verdict == '0 && delta_mv == '0));
  assert_contact_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && contact_fail) |=> verdict[V_CONTF]);
  assert_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && !contact_fail && samp_first_mv < MV_W'(SHORT_MV)) |=> verdict[V_SHORT]);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> delta_mv <= D_W'(DELTA_MAX));
endmodule

bind verdict_sorter vs_check #(
  .MV_W(MV_W), .D_W(D_W), .DELTA_MAX(DELTA_MAX), .SHORT_MV(SHORT_MV)
) u_vs_check (
  .clk          (clk),
  .rst_n        (rst_n),
  .eval_req     (eval_req),
  .contact_fail (contact_fail),
  .samp_first_mv(samp_first_mv),
  .verdict      (verdict),
  .verdict_vld  (verdict_vld),
  .delta_mv     (delta_mv)
);

// File: tb/verdict_sorter_bench.sv
module verdict_sorter_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_req = 1'b0;
  logic        contact_fail = 1'b0, avalanche = 1'b0, oscillation = 1'b0;
  logic [11:0] samp_first_mv = '0, samp_second_mv = '0;
  logic [10:0] limit_hi_mv = '0, limit_lo_mv = '0;
  logic [8:0]  verdict;
  logic        verdict_vld;
  logic [10:0] delta_mv;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  verdict_sorter u_verdict_sorter (
    .clk(clk), .rst_n(rst_n), .eval_req(eval_req),
    .contact_fail(contact_fail), .avalanche(avalanche), .oscillation(oscillation),
    .samp_first_mv(samp_first_mv), .samp_second_mv(samp_second_mv),
    .limit_hi_mv(limit_hi_mv), .limit_lo_mv(limit_lo_mv),
    .verdict(verdict), .verdict_vld(verdict_vld), .delta_mv(delta_mv)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected verdict bit index, straight from the precedence chain
  function automatic int exp_idx(bit cf, bit av, bit os, int f, int s, int hi, int lo);
    int d;
    if (cf)          return 8;
    if (f < 200)     return 7;
    if (f > 3000)    return 6;
    if (av)          return 5;
    if (f < s)       return 4;
    if (os)          return 3;
    d = f - s;
    if (d > 1999) d = 1999;
    if (d > hi)      return 2;
    if (d < lo)      return 1;
    return 0;
  endfunction

  function automatic int exp_delta(int f, int s);
    if (f < s) return 0;
    return (f - s > 1999) ? 1999 : f - s;
  endfunction

  function automatic string tag(int idx);
    case (idx)
      8:       return "R2";
      7, 6:    return "R3";
      5:       return "R4";
      4:       return "R5";
      3:       return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic run(bit cf, bit av, bit os, int f, int s, int hi, int lo);
    int e;
    @(negedge clk);
    contact_fail = cf; avalanche = av; oscillation = os;
    samp_first_mv = 12'(f); samp_second_mv = 12'(s);
    limit_hi_mv = 11'(hi); limit_lo_mv = 11'(lo);
    eval_req = 1'b1;
    @(negedge clk);
    eval_req = 1'b0;
    e = exp_idx(cf, av, os, f, s, hi, lo);
    chk("R1", int'(verdict_vld), 1);
    chk(tag(e), int'(verdict), 1 << e);
    chk("R7", int'(delta_mv), exp_delta(f, s));
    @(negedge clk);
    chk("R1", int'(verdict_vld), 0);
    chk("R1", int'(verdict), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", int'(verdict_vld), 0);
    chk("R1", int'(verdict), 0);
    chk("R1", int'(delta_mv), 0);
    rst_n = 1'b1;

    // directed corners
    run(1, 1, 1, 100, 900, 10, 5);     // R2 contact beats everything
    run(0, 1, 1, 199, 0, 10, 5);       // R3 short
    run(0, 0, 0, 200, 100, 200, 50);   // R3 edge not short, R8 pass
    run(0, 1, 0, 3001, 0, 10, 5);      // R3 open
    run(0, 0, 0, 3000, 1000, 1999, 0); // R3 edge not open, R7 delta 1999
    run(0, 1, 1, 800, 900, 10, 5);     // R4 avalanche over sign error
    run(0, 0, 1, 800, 900, 10, 5);     // R5 sign error over oscillation
    run(0, 0, 1, 900, 800, 10, 5);     // R6 oscillation over limits
    run(0, 0, 0, 900, 900, 0, 0);      // R8 zero delta passes
    run(0, 0, 0, 2500, 201, 1999, 0);  // R7 saturation, R8 equals hi passes
    run(0, 0, 0, 1000, 500, 499, 0);   // R8 high by one
    run(0, 0, 0, 1000, 500, 1999, 501);// R8 low by one
    run(0, 0, 0, 1000, 500, 500, 500); // R8 on both limits: pass
    run(0, 0, 0, 1000, 500, 100, 900); // R8 high wins over low

    for (int n = 0; n < 600; n++) begin
      int f, s, hi, lo;
      f  = ($urandom % 4 == 0) ? $urandom % 4096 : 200 + $urandom % 2801;
      s  = ($urandom % 5 == 0) ? f + $urandom % 50 : ((f > 0) ? f - ($urandom % (f + 1)) : 0);
      if (s > 4095) s = 4095;
      hi = $urandom % 2000;
      lo = $urandom % 2000;
      run(($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 8) == 0, f, s, hi, lo);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule